// File: doc/BRIEF.md
# Amplifier control register slave on a two-wire serial bus

This block lets a host configure a small stereo headphone amplifier over a standard I2C bus. It watches the bus clock and data lines through synchronisers clocked by the system clock, recognises START and STOP, compares the address byte with a fixed 7-bit address, and answers by pulling the data line low through an open-drain output. It holds five 8-bit registers: a status register built live from three fault flags, a mode register, a volume register, a register that reads as zero, and an identification register.

There is no register-pointer byte. The byte's position in the transaction picks the register. In a write, the first data byte lands in the mode register and every later byte lands in the volume register, so a host can ramp the volume quickly in one transaction. Each read begins at the status register and walks through all five registers in a fixed circle for as long as the host acknowledges. The amplifier side receives the register contents and two strobes. One marks a mode update. The other marks any register write and is used to clear latched faults.

A master-standby input, active low, holds the whole interface and both writable registers in reset. The system clock must run at least 16 times faster than the bus clock. Bus clocks up to 400 kHz are supported.

Top module: `amp_ctl_i2c_slave`

## Requirements
- R1: While `rst_n` or `stby_n` is low, `mode_o` is 00h, the mute outputs and `vol_code_o` are 0, and `sda_pd_o` is 0. An address byte sent in that state is not acknowledged.
- R2: The slave address is 7'b1100000. Address byte C0h (write) and C1h (read) are acknowledged: `sda_pd_o` is high during the ninth clock. Any other address gets no acknowledge, and the rest of that transaction changes no register.
- R3: Bytes move MSB first. The slave acknowledges every data byte of an accepted write.
- R4: In a write, the first data byte after the address loads the mode register (`mode_o`). Every later byte up to STOP or repeated START loads the volume register. The next write transaction starts again at the mode register.
- R5: `mode_wr_o` is a one-clock pulse in the cycle `mode_o` takes a new value, at the falling clock edge that ends the byte's eighth bit. `wr_evt_o` pulses once for every data byte written. For a first byte, both pulses fall in the same cycle.
- R6: A read returns the register at index 0, 1, 2, 3, 4, then index 0 again, advancing after each byte the host acknowledges. A host NACK ends the read. Every read starts at index 0.
- R7: Index 0 reads {`sc_left_i`, `sc_right_i`, `therm_i`, 5'b00000}, with the left flag in bit 7. Index 3 reads 00h and index 4 reads 01h. Indices 1 and 2 return the mode and volume registers.
- R8: In the volume register, bit 7 drives `mute_l_o`, bit 6 drives `mute_r_o` and bits 5:0 drive `vol_code_o`.
- R9: A STOP releases `sda_pd_o` and ends the transaction. A START seen at any point, including in the middle of a transaction, begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_n | input | 1 | Master standby, active low, holds the block in reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pd_o | output | 1 | Pull the data line low when 1 |
| sc_left_i | input | 1 | Left short-circuit flag |
| sc_right_i | input | 1 | Right short-circuit flag |
| therm_i | input | 1 | Thermal fault flag |
| mode_o | output | 8 | Mode register contents |
| mute_l_o | output | 1 | Left mute |
| mute_r_o | output | 1 | Right mute |
| vol_code_o | output | 6 | Volume code |
| mode_wr_o | output | 1 | Mode register write strobe |
| wr_evt_o | output | 1 | Strobe for any register write |

## Verification
The mode-write strobe and the general write-event strobe coincide on the first data byte of every write. On later bytes only the write-event strobe fires. The bench provokes this by writing one mode byte followed by several volume bytes. For each byte, its scoreboard records whether a mode strobe is expected together with the value the register must show. The monitor samples both strobes and the register outputs in the same cycle. A mode strobe seen without the event strobe, or a strobe the scoreboard did not expect, counts as a failure.

// File: rtl/amp_i2c_pkg.sv
package amp_i2c_pkg;
  localparam int unsigned NUM_REGS = 5;
  localparam int unsigned IDX_W    = $clog2(NUM_REGS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WDAT, ST_WACK, ST_RDAT, ST_RACK
  } i2c_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int unsigned PW = STAGES + 1;

  logic [1:0][PW-1:0] pipe_q;
  logic [1:0]         line_in;

  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q[g] <= '1;
      else        pipe_q[g] <= {pipe_q[g][PW-2:0], line_in[g]};
    end
  end

  logic scl_now, scl_old, sda_old;
  assign scl_now   = pipe_q[0][PW-2];
  assign scl_old   = pipe_q[0][PW-1];
  assign sda_s     = pipe_q[1][PW-2];
  assign sda_old   = pipe_q[1][PW-1];
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_s;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import amp_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_byte,
  output logic [IDX_W-1:0] rd_idx,
  output logic             sda_pd,
  output logic             wr_en,
  output logic             wr_first,
  output logic [7:0]       wr_data
);
  localparam logic [3:0]       LAST_BIT = 4'd8;
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(NUM_REGS - 1);

  i2c_st_e          st_q, st_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       sr_q, sr_n;
  logic             rw_q, rw_n, first_q, first_n, pd_q, pd_n, mack_q, mack_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             wr_n;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sr_n = sr_q; rw_n = rw_q;
    first_n = first_q; pd_n = pd_q; mack_n = mack_q; idx_n = idx_q;
    wr_n = 1'b0;
    if (stop_det) begin
      st_n = ST_IDLE; pd_n = 1'b0;
    end else if (start_det) begin
      st_n = ST_ADDR; cnt_n = '0; pd_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise && cnt_q < LAST_BIT) begin
            sr_n  = {sr_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == LAST_BIT) begin
            if (st_q == ST_WDAT) begin
              wr_n = 1'b1; st_n = ST_WACK; pd_n = 1'b1;
            end else if (sr_q[7:1] == DEV_ADDR) begin
              st_n = ST_AACK; pd_n = 1'b1; rw_n = sr_q[0];
              first_n = 1'b1; idx_n = '0;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          cnt_n = '0;
          if (rw_q) begin
            st_n = ST_RDAT; sr_n = rd_byte; pd_n = ~rd_byte[7];
          end else begin
            st_n = ST_WDAT; pd_n = 1'b0;
          end
        end
        ST_WACK: if (scl_fall) begin
          st_n = ST_WDAT; cnt_n = '0; pd_n = 1'b0; first_n = 1'b0;
        end
        ST_RDAT: begin
          if (scl_rise && cnt_q < LAST_BIT) begin
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              st_n = ST_RACK; pd_n = 1'b0;
            end else begin
              sr_n = {sr_q[6:0], 1'b0}; pd_n = ~sr_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
            if (!sda_s) idx_n = (idx_q == IDX_TOP) ? '0 : idx_q + 1'b1;
          end else if (scl_fall) begin
            if (mack_q) begin
              st_n = ST_RDAT; cnt_n = '0; sr_n = rd_byte; pd_n = ~rd_byte[7];
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sr_q <= '0; rw_q <= 1'b0;
      first_q <= 1'b0; pd_q <= 1'b0; mack_q <= 1'b0; idx_q <= '0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sr_q <= sr_n; rw_q <= rw_n;
      first_q <= first_n; pd_q <= pd_n; mack_q <= mack_n; idx_q <= idx_n;
    end
  end

  assign rd_idx   = idx_q;
  assign sda_pd   = pd_q;
  assign wr_en    = wr_n;
  assign wr_first = first_q;
  assign wr_data  = sr_q;

  // R2: no pull-down while not addressed
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_IDLE |-> !pd_q);
  // R9: a STOP always releases the line and ends the transaction
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!pd_q && st_q == ST_IDLE));
  // R6: read index stays inside the register set
  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_TOP);
  // R6: host NACK ends the read
  p_nack_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RACK && scl_fall && !mack_q && !start_det && !stop_det)
      |=> st_q == ST_IDLE);
endmodule

// File: rtl/amp_reg_bank.sv
module amp_reg_bank
  import amp_i2c_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_first,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             sc_l,
  input  logic             sc_r,
  input  logic             therm,
  output logic [7:0]       rd_byte,
  output logic [7:0]       mode_q,
  output logic [7:0]       vol_q,
  output logic             mode_wr,
  output logic             wr_evt
);
  logic mode_en, vol_en;
  assign mode_en = wr_en & wr_first;
  assign vol_en  = wr_en & ~wr_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; vol_q <= '0; mode_wr <= 1'b0; wr_evt <= 1'b0;
    end else begin
      if (mode_en) mode_q <= wr_data;
      if (vol_en)  vol_q  <= wr_data;
      mode_wr <= mode_en;
      wr_evt  <= wr_en;
    end
  end

  always_comb begin
    unique case (rd_idx)
      IDX_W'(0): rd_byte = {sc_l, sc_r, therm, 5'b00000};
      IDX_W'(1): rd_byte = mode_q;
      IDX_W'(2): rd_byte = vol_q;
      IDX_W'(4): rd_byte = ID_VALUE;
      default:   rd_byte = 8'h00;
    endcase
  end

  // R4: a first byte hits the mode register and leaves volume alone
  p_first_to_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |=> (mode_wr && wr_evt && $stable(vol_q)));
  // R5: mode strobe is a single cycle and always comes with the event strobe
  p_mode_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |-> (wr_evt ##1 !mode_wr));
endmodule

// File: rtl/amp_ctl_i2c_slave.sv
module amp_ctl_i2c_slave
  import amp_i2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h60,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  ID_VALUE    = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pd_o,
  input  logic       sc_left_i,
  input  logic       sc_right_i,
  input  logic       therm_i,
  output logic [7:0] mode_o,
  output logic       mute_l_o,
  output logic       mute_r_o,
  output logic [5:0] vol_code_o,
  output logic       mode_wr_o,
  output logic       wr_evt_o
);
  logic       arst_n;
  logic [1:0] rsync_q;
  logic       rst_q_n;

  assign arst_n = rst_n & stby_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q_n = rsync_q[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, wr_first;
  logic [7:0] wr_data, rd_byte, vol_q;
  logic [IDX_W-1:0] rd_idx;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_q_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_byte(rd_byte), .rd_idx(rd_idx), .sda_pd(sda_pd_o),
    .wr_en(wr_en), .wr_first(wr_first), .wr_data(wr_data)
  );

  amp_reg_bank #(.ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_en), .wr_first(wr_first),
    .wr_data(wr_data), .rd_idx(rd_idx), .sc_l(sc_left_i),
    .sc_r(sc_right_i), .therm(therm_i), .rd_byte(rd_byte),
    .mode_q(mode_o), .vol_q(vol_q), .mode_wr(mode_wr_o), .wr_evt(wr_evt_o)
  );

  assign mute_l_o   = vol_q[7];
  assign mute_r_o   = vol_q[6];
  assign vol_code_o = vol_q[5:0];

  // R1: standby keeps the line released and the registers cleared
  p_stby_clear_r1: assert property (@(posedge clk)
    !rst_q_n |-> (!sda_pd_o && mode_o == 8'h00 && vol_q == 8'h00));
endmodule

// File: tb/amp_ctl_i2c_slave_bench.sv
module amp_ctl_i2c_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, stby_n, scl_m, sda_m, sc_l, sc_r, th;
  logic sda_pd_o, mute_l_o, mute_r_o, mode_wr_o, wr_evt_o;
  logic [7:0] mode_o;
  logic [5:0] vol_code_o;
  logic sda_line;

  assign sda_line = sda_m & ~sda_pd_o;

  amp_ctl_i2c_slave u_amp_ctl_i2c_slave (
    .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pd_o(sda_pd_o), .sc_left_i(sc_l), .sc_right_i(sc_r), .therm_i(th),
    .mode_o(mode_o), .mute_l_o(mute_l_o), .mute_r_o(mute_r_o),
    .vol_code_o(vol_code_o), .mode_wr_o(mode_wr_o), .wr_evt_o(wr_evt_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m_cr1 = 8'h00, m_cr2 = 8'h00;

  typedef struct packed { logic is_mode; logic [7:0] val; } wr_item_t;
  wr_item_t exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: R5 strobes, R4/R8 register contents
  always @(negedge clk) begin
    if (rst_n && stby_n && (wr_evt_o || mode_wr_o)) begin
      if (!wr_evt_o) chk(1'b0, "R5 mode strobe without event", 32'(mode_wr_o), 0);
      else if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write strobe", 32'(mode_o), 0);
      else begin
        wr_item_t it;
        it = exp_q.pop_front();
        chk(mode_wr_o == it.is_mode, "R5 mode strobe with event", 32'(mode_wr_o), 32'(it.is_mode));
        if (it.is_mode) chk(mode_o == it.val, "R4 mode register", 32'(mode_o), 32'(it.val));
        else chk({mute_l_o, mute_r_o, vol_code_o} == it.val, "R4 R8 volume register",
                 32'({mute_l_o, mute_r_o, vol_code_o}), 32'(it.val));
      end
    end
  end

  task automatic waitq(input int n);
    repeat (n * Q) @(posedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitq(1); scl_m = 1'b1; waitq(1);
    sda_m = 1'b0; waitq(1); scl_m = 1'b0; waitq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitq(1); scl_m = 1'b1; waitq(1); sda_m = 1'b1; waitq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; waitq(1); scl_m = 1'b1; waitq(2); scl_m = 1'b0; waitq(1);
    end
    sda_m = 1'b1; waitq(1); scl_m = 1'b1; waitq(1);
    @(negedge clk); acked = ~sda_line;
    waitq(1); scl_m = 1'b0; waitq(1);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(1); scl_m = 1'b1; waitq(1);
      @(negedge clk); b[i] = sda_line;
      waitq(1); scl_m = 1'b0;
    end
    waitq(1); sda_m = ~give_ack; waitq(1); scl_m = 1'b1; waitq(2);
    scl_m = 1'b0; waitq(1); sda_m = 1'b1;
  endtask

  task automatic wr_data(input logic [7:0] b, input logic first);
    logic a;
    exp_q.push_back({first, b});
    if (first) m_cr1 = b; else m_cr2 = b;
    send_byte(b, a);
    chk(a == 1'b1, "R3 data byte acknowledged", 32'(a), 1);
  endtask

  function automatic logic [7:0] exp_reg(input int idx);
    case (idx)
      0: return {sc_l, sc_r, th, 5'b0};
      1: return m_cr1;
      2: return m_cr2;
      4: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic read_n(input int n, input string tag);
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hC1, a);
    chk(a == 1'b1, "R2 read address C1 acknowledged", 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b == exp_reg(k % 5), tag, 32'(b), 32'(exp_reg(k % 5)));
    end
    bus_stop();
  endtask

  initial begin
    logic a;
    rst_n = 1'b0; stby_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    sc_l = 1'b0; sc_r = 1'b0; th = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sda_pd_o == 1'b0 && mode_o == 8'h00 && vol_code_o == 6'd0 && !mute_l_o && !mute_r_o,
        "R1 reset state", 32'({sda_pd_o, mode_o, vol_code_o}), 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R4 R5 R8: mode byte then two volume bytes
    bus_start();
    send_byte(8'hC0, a);
    chk(a == 1'b1, "R2 write address C0 acknowledged", 32'(a), 1);
    wr_data(8'h03, 1'b1);
    wr_data(8'h8A, 1'b0);
    wr_data(8'hC5, 1'b0);
    bus_stop();
    @(negedge clk);
    chk(mute_l_o && mute_r_o && vol_code_o == 6'd5, "R8 mute and volume fields",
        32'({mute_l_o, mute_r_o, vol_code_o}), 32'({2'b11, 6'd5}));
    chk(mode_o == 8'h03, "R4 mode kept after volume bytes", 32'(mode_o), 32'h03);

    // R6 R7: wrap-around read with flags
    sc_l = 1'b1; th = 1'b1;
    read_n(7, "R6 R7 read sequence with wrap");
    sc_l = 1'b0; sc_r = 1'b1; th = 1'b0;
    read_n(1, "R6 read restarts at index 0");

    // R2: wrong address ignored
    bus_start();
    send_byte(8'hA0, a);
    chk(a == 1'b0, "R2 foreign address not acknowledged", 32'(a), 0);
    send_byte(8'h77, a);
    chk(a == 1'b0, "R2 data after foreign address not acknowledged", 32'(a), 0);
    bus_stop();
    chk(mode_o == 8'h03, "R2 foreign write leaves mode", 32'(mode_o), 32'h03);

    // R9 R4: repeated start restarts at the mode register
    bus_start();
    send_byte(8'hC0, a);
    wr_data(8'h07, 1'b1);
    bus_start();
    send_byte(8'hC0, a);
    chk(a == 1'b1, "R9 address after repeated start", 32'(a), 1);
    wr_data(8'h02, 1'b1);
    wr_data(8'h11, 1'b0);
    bus_stop();
    @(negedge clk);
    chk(sda_pd_o == 1'b0, "R9 line released after stop", 32'(sda_pd_o), 0);
    read_n(3, "R4 R9 registers after repeated start");

    // R1: master standby
    stby_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mode_o == 8'h00 && {mute_l_o, mute_r_o, vol_code_o} == 8'h00 && !sda_pd_o,
        "R1 standby clears registers", 32'({mode_o, mute_l_o, mute_r_o, vol_code_o}), 0);
    bus_start();
    send_byte(8'hC0, a);
    chk(a == 1'b0, "R1 no acknowledge in standby", 32'(a), 0);
    bus_stop();
    stby_n = 1'b1; m_cr1 = 8'h00; m_cr2 = 8'h00;
    repeat (5) @(posedge clk);
    read_n(3, "R1 registers after standby");

    chk(exp_q.size() == 0, "R5 all expected strobes seen", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule